// File: doc/BRIEF.md
# Global Timer with Write Acknowledge

This block is a free-running 64-bit timer with one 64-bit comparator, reached over a simple 32-bit register bus. Software programs a comparator value and an increment. Each time the counter equals the comparator, an interrupt flag is latched. If reloading is enabled, the comparator then advances by the increment, so periodic events stay locked to the counter and do not drift.

Writes to the counter halves, the comparator halves, the increment and the control register do not take effect at once. They travel through a fixed-latency commit path, which models a crossing into a slower timer domain. When a write lands, it raises its own acknowledge bit in one of two status words. Software polls that bit and then clears it by writing a 1. The interrupt enable and interrupt flag registers act in the next cycle and raise no acknowledge.

The counter halves are read without latching. Software reads the high half, then the low half, then the high half again, and repeats the sequence if the two high values differ.

Top module: `gtimer_wack`

## Requirements
- R1: After reset, every register (word addresses 0 to 9) reads 0 and `irq` is 0.
- R2: When control bit 0 (run) is 1, the counter rises by one every cycle. When that bit is 0, the counter holds its value.
- R3: A write to word 0 (counter low) or word 1 (counter high) takes effect COMMIT_LAT cycles after the cycle in which it is sampled. The old value stays readable until then. In the cycle the new value takes effect, bit 0 (low) or bit 1 (high) of word 8 is set.
- R4: Writes to word 2 (comparator low), word 3 (comparator high), word 4 (increment) and word 5 (control) also commit after COMMIT_LAT cycles. They set bits 0, 1, 2 and 3 of word 9 respectively, in the cycle they take effect.
- R5: Writing word 8 or word 9 clears each status bit written as 1 and leaves each bit written as 0 unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R6: Writes to word 6 (interrupt enable, bit 0) and word 7 (interrupt flag) take effect in the next cycle and set no status bit.
- R7: While run and control bit 1 (compare enable) are both 1, a cycle in which the counter equals the comparator sets bit 0 of word 7 at the next edge. With compare enable at 0, no flag is raised.
- R8: On a match with control bit 2 (reload) at 1, the comparator becomes its old value plus the 32-bit increment. With reload at 0, the comparator keeps its value.
- R9: `irq` is the interrupt flag ANDed with the interrupt enable. Writing 1 to bit 0 of word 7 clears the flag.
- R10: A committed write replaces only its own counter half, and the other half keeps its value in that cycle. When the counter runs, a carry passes from the low half into the high half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, together with bus_sel |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume at most one bus write per cycle and only word addresses 0 to 9. They also assume that a comparator write never lands in the same cycle as a reload; in that case the write takes priority. The stimulus applies one access per cycle. It changes the counter and comparator only while the counter is stopped or far away from the comparator. Every timed check is placed at a cycle counted from the write's sampling edge plus the commit latency.

// File: rtl/gtw_pkg.sv
package gtw_pkg;

    localparam int DW      = 32;
    localparam int AW      = 4;
    localparam int CW      = 2 * DW;
    localparam int CTRL_W  = 3;
    localparam int CWST_W  = 2;
    localparam int GWST_W  = 4;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_EN   = 1;
    localparam int CTRL_AUTO = 2;

    typedef enum logic [AW-1:0] {
        A_CNT_LO = 4'd0,
        A_CNT_HI = 4'd1,
        A_CMP_LO = 4'd2,
        A_CMP_HI = 4'd3,
        A_INCR   = 4'd4,
        A_CTRL   = 4'd5,
        A_IEN    = 4'd6,
        A_ISTAT  = 4'd7,
        A_CWST   = 4'd8,
        A_GWST   = 4'd9
    } reg_addr_e;

    typedef enum logic [2:0] {
        T_CNT_LO = 3'd0,
        T_CNT_HI = 3'd1,
        T_CMP_LO = 3'd2,
        T_CMP_HI = 3'd3,
        T_INCR   = 3'd4,
        T_CTRL   = 3'd5
    } tgt_e;

    localparam int NTGT = 6;

    typedef struct packed {
        logic          valid;
        tgt_e          tgt;
        logic [DW-1:0] data;
    } commit_t;

    function automatic commit_t classify(input logic wr,
                                         input logic [AW-1:0] a,
                                         input logic [DW-1:0] d);
        commit_t c;
        c.valid = 1'b0;
        c.tgt   = T_CNT_LO;
        c.data  = d;
        if (wr) begin
            case (a)
                A_CNT_LO: begin c.valid = 1'b1; c.tgt = T_CNT_LO; end
                A_CNT_HI: begin c.valid = 1'b1; c.tgt = T_CNT_HI; end
                A_CMP_LO: begin c.valid = 1'b1; c.tgt = T_CMP_LO; end
                A_CMP_HI: begin c.valid = 1'b1; c.tgt = T_CMP_HI; end
                A_INCR:   begin c.valid = 1'b1; c.tgt = T_INCR;   end
                A_CTRL:   begin c.valid = 1'b1; c.tgt = T_CTRL;   end
                default:  c.valid = 1'b0;
            endcase
        end
        return c;
    endfunction

    function automatic logic [NTGT-1:0] strobes(input commit_t c);
        logic [NTGT-1:0] s;
        s = '0;
        if (c.valid) s[c.tgt] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/gtw_commit_pipe.sv
module gtw_commit_pipe
    import gtw_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  commit_t in_c,
    output commit_t out_c
);
    commit_t stg [LAT];

    genvar g;
    generate
        for (g = 0; g < LAT; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= in_c;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) stg[g] <= '0;
                    else     stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign out_c = stg[LAT-1];
endmodule

// File: rtl/gtw_counter.sv
module gtw_counter
    import gtw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[DW-1:0]  <= wdata;
            if (wr_hi) cnt[CW-1:DW] <= wdata;
        end else if (run) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/gtw_comparator.sv
module gtw_comparator
    import gtw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    input  logic          run,
    input  logic          en,
    input  logic          auto_inc,
    input  logic [DW-1:0] incr,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cmp,
    output logic          hit
);
    assign hit = run && en && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cmp[DW-1:0]  <= wdata;
            if (wr_hi) cmp[CW-1:DW] <= wdata;
        end else if (hit && auto_inc) begin
            cmp <= cmp + {{(CW-DW){1'b0}}, incr};
        end
    end
endmodule

// File: rtl/gtw_wstat.sv
module gtw_wstat #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] bits
);
    logic [N-1:0] clr_eff;
    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) bits <= '0;
        else     bits <= (bits & ~clr_eff) | set;
    end
endmodule

// File: rtl/gtimer_wack.sv
module gtimer_wack
    import gtw_pkg::*;
#(
    parameter int COMMIT_LAT = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    logic            wr;
    commit_t         req_c;
    commit_t         cmt;
    logic [NTGT-1:0] cstb;

    logic [CW-1:0]     cnt;
    logic [CW-1:0]     cmp;
    logic              hit;
    logic [DW-1:0]     incr_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              ien_q;
    logic              istat_q;
    logic [CWST_W-1:0] cwst;
    logic [GWST_W-1:0] gwst;

    logic run_w, en_w, auto_w;
    logic cnt_wr, cmp_wr;

    assign wr    = bus_sel && bus_we;
    assign req_c = classify(wr, bus_addr, bus_wdata);

    gtw_commit_pipe #(.LAT(COMMIT_LAT)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .in_c  (req_c),
        .out_c (cmt)
    );

    assign cstb   = strobes(cmt);
    assign run_w  = ctrl_q[CTRL_RUN];
    assign en_w   = ctrl_q[CTRL_EN];
    assign auto_w = ctrl_q[CTRL_AUTO];
    assign cnt_wr = cstb[T_CNT_LO] || cstb[T_CNT_HI];
    assign cmp_wr = cstb[T_CMP_LO] || cstb[T_CMP_HI];

    gtw_counter u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (run_w),
        .wr_lo (cstb[T_CNT_LO]),
        .wr_hi (cstb[T_CNT_HI]),
        .wdata (cmt.data),
        .cnt   (cnt)
    );

    gtw_comparator u_cmp (
        .clk      (clk),
        .rst      (rst),
        .cnt      (cnt),
        .run      (run_w),
        .en       (en_w),
        .auto_inc (auto_w),
        .incr     (incr_q),
        .wr_lo    (cstb[T_CMP_LO]),
        .wr_hi    (cstb[T_CMP_HI]),
        .wdata    (cmt.data),
        .cmp      (cmp),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            incr_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (cstb[T_INCR]) incr_q <= cmt.data;
            if (cstb[T_CTRL]) ctrl_q <= cmt.data[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= 1'b0;
            istat_q <= 1'b0;
        end else begin
            if (wr && bus_addr == A_IEN) ien_q <= bus_wdata[0];
            istat_q <= hit || (istat_q && !(wr && bus_addr == A_ISTAT && bus_wdata[0]));
        end
    end

    gtw_wstat #(.N(CWST_W)) u_cwst (
        .clk      (clk),
        .rst      (rst),
        .set      ({cstb[T_CNT_HI], cstb[T_CNT_LO]}),
        .clr_we   (wr && bus_addr == A_CWST),
        .clr_mask (bus_wdata[CWST_W-1:0]),
        .bits     (cwst)
    );

    gtw_wstat #(.N(GWST_W)) u_gwst (
        .clk      (clk),
        .rst      (rst),
        .set      ({cstb[T_CTRL], cstb[T_INCR], cstb[T_CMP_HI], cstb[T_CMP_LO]}),
        .clr_we   (wr && bus_addr == A_GWST),
        .clr_mask (bus_wdata[GWST_W-1:0]),
        .bits     (gwst)
    );

    assign irq = istat_q && ien_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CNT_LO: bus_rdata = cnt[DW-1:0];
            A_CNT_HI: bus_rdata = cnt[CW-1:DW];
            A_CMP_LO: bus_rdata = cmp[DW-1:0];
            A_CMP_HI: bus_rdata = cmp[CW-1:DW];
            A_INCR:   bus_rdata = incr_q;
            A_CTRL:   bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
            A_IEN:    bus_rdata = {{(DW-1){1'b0}}, ien_q};
            A_ISTAT:  bus_rdata = {{(DW-1){1'b0}}, istat_q};
            A_CWST:   bus_rdata = {{(DW-CWST_W){1'b0}}, cwst};
            A_GWST:   bus_rdata = {{(DW-GWST_W){1'b0}}, gwst};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gtw_checker.sv
module gtw_checker
    import gtw_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          run,
    input logic          cmp_en,
    input logic          auto_inc,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] cmp,
    input logic [DW-1:0] incr,
    input logic          cnt_wr,
    input logic          cmp_wr,
    input logic          cnt_lo_stb,
    input logic [1:0]    cwst,
    input logic          istat,
    input logic          ien,
    input logic          irq
);
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !cnt_wr) |=> (cnt == $past(cnt) + CW'(1)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt));

    p_ack_lo_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_lo_stb |=> cwst[0]);

    p_match_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (run && cmp_en && cnt == cmp) |=> istat);

    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        (run && cmp_en && auto_inc && cnt == cmp && !cmp_wr)
            |=> (cmp == $past(cmp) + {{(CW-DW){1'b0}}, $past(incr)}));

    p_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (!auto_inc && !cmp_wr) |=> $stable(cmp));

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (istat && ien));
endmodule

bind gtimer_wack gtw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run_w),
    .cmp_en     (en_w),
    .auto_inc   (auto_w),
    .cnt        (cnt),
    .cmp        (cmp),
    .incr       (incr_q),
    .cnt_wr     (cnt_wr),
    .cmp_wr     (cmp_wr),
    .cnt_lo_stb (cstb[T_CNT_LO]),
    .cwst       (cwst),
    .istat      (istat_q),
    .ien        (ien_q),
    .irq        (irq)
);

// File: tb/tb_gtimer_wack.sv
`timescale 1ns/1ps
module tb_gtimer_wack;
    import gtw_pkg::*;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    gtimer_wack #(.COMMIT_LAT(3)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [3:0]  addr;
        logic [31:0] exp;
        int          req;
    } item_t;

    item_t sbq[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    // Scoreboard monitor: compares each queued expectation mid-cycle.
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        while (sbq.size() > 0) begin
            it  = sbq.pop_front();
            act = it.is_irq ? {31'b0, irq} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL R%0d addr=%0d actual=%h expected=%h",
                         it.req, it.addr, act, it.exp);
            end
        end
    end

    task automatic win();
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_we  = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) win();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk);
        #1;
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input int req);
        item_t it;
        win();
        bus_addr = a;
        it.is_irq = 1'b0;
        it.addr   = a;
        it.exp    = e;
        it.req    = req;
        sbq.push_back(it);
    endtask

    task automatic rdirq(input logic e, input int req);
        item_t it;
        win();
        it.is_irq = 1'b1;
        it.addr   = 4'hF;
        it.exp    = {31'b0, e};
        it.req    = req;
        sbq.push_back(it);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state of every word and the interrupt line
        for (int a = 0; a < 10; a++) rd(4'(a), 32'h0, 1);
        rdirq(1'b0, 1);

        // R3: counter-low write lands three cycles after sampling
        wr(A_CNT_LO, 32'h10);
        rd(A_CNT_LO, 32'h0, 3);
        rd(A_CNT_LO, 32'h0, 3);
        rd(A_CWST, 32'h0, 3);
        rd(A_CNT_LO, 32'h10, 3);
        rd(A_CWST, 32'h1, 3);
        wr(A_CNT_HI, 32'hAB);
        idle(3);
        rd(A_CNT_HI, 32'hAB, 3);
        rd(A_CNT_LO, 32'h10, 10); // R10: other half untouched
        rd(A_CWST, 32'h3, 3);

        // R5: write-one-to-clear, zero has no effect
        wr(A_CWST, 32'h2);
        rd(A_CWST, 32'h1, 5);
        wr(A_CWST, 32'h0);
        rd(A_CWST, 32'h1, 5);
        wr(A_CWST, 32'h1);
        rd(A_CWST, 32'h0, 5);
        // R5: set beats clear in the same cycle
        wr(A_CNT_LO, 32'h10);
        idle(2);
        wr(A_CWST, 32'h1);
        rd(A_CWST, 32'h1, 5);
        wr(A_CWST, 32'h1);
        rd(A_CWST, 32'h0, 5);

        // R4: four delayed writes, status bits appear in order
        wr(A_CMP_LO, 32'h40);
        wr(A_CMP_HI, 32'hAB);
        wr(A_INCR, 32'h20);
        wr(A_CTRL, 32'h0);
        rd(A_GWST, 32'h1, 4);
        rd(A_GWST, 32'h3, 4);
        rd(A_GWST, 32'h7, 4);
        rd(A_GWST, 32'hF, 4);
        rd(A_CMP_LO, 32'h40, 4);
        rd(A_CMP_HI, 32'hAB, 4);
        rd(A_INCR, 32'h20, 4);
        rd(A_CTRL, 32'h0, 4);

        // R6: immediate registers, no status side effects
        wr(A_IEN, 32'h1);
        rd(A_IEN, 32'h1, 6);
        wr(A_ISTAT, 32'h1);
        idle(3);
        rd(A_CWST, 32'h0, 6);
        rd(A_GWST, 32'hF, 6);
        wr(A_GWST, 32'hF);
        rd(A_GWST, 32'h0, 5);

        // R2: run, then stop
        wr(A_CTRL, 32'h1);
        idle(2);
        rd(A_CNT_LO, 32'h10, 2);
        rd(A_CNT_LO, 32'h10, 2);
        rd(A_CNT_LO, 32'h11, 2);
        rd(A_CNT_LO, 32'h12, 2);
        wr(A_CTRL, 32'h0);
        idle(3);
        rd(A_CNT_LO, 32'h17, 2);
        rd(A_CNT_LO, 32'h17, 2);

        // R7 / R8 / R9: periodic match with reload
        wr(A_CNT_LO, 32'h3C);
        idle(3);
        rd(A_CNT_LO, 32'h3C, 10);
        wr(A_CTRL, 32'h7);
        idle(7);
        rd(A_ISTAT, 32'h0, 7);
        rd(A_ISTAT, 32'h1, 7);
        rdirq(1'b1, 9);
        rd(A_CMP_LO, 32'h60, 8);
        wr(A_ISTAT, 32'h1);
        rd(A_ISTAT, 32'h0, 9);
        rdirq(1'b0, 9);
        idle(26);
        rd(A_ISTAT, 32'h1, 8);
        rd(A_CMP_LO, 32'h80, 8);
        wr(A_CTRL, 32'h0);
        wr(A_ISTAT, 32'h1);
        idle(3);

        // R7: no flag when compare enable is off
        wr(A_CNT_LO, 32'h7C);
        idle(3);
        wr(A_CTRL, 32'h1);
        idle(10);
        rd(A_ISTAT, 32'h0, 7);
        rd(A_CMP_LO, 32'h80, 8);
        wr(A_CTRL, 32'h0);
        idle(3);

        // R8: match without reload keeps the comparator
        wr(A_CNT_LO, 32'h7C);
        idle(3);
        wr(A_CTRL, 32'h3);
        idle(8);
        rd(A_ISTAT, 32'h1, 7);
        rd(A_CMP_LO, 32'h80, 8);
        rdirq(1'b1, 9);
        wr(A_IEN, 32'h0);
        rdirq(1'b0, 9); // R9: gated by enable

        // R10: carry from low half into high half
        wr(A_CTRL, 32'h0);
        idle(3);
        wr(A_CNT_LO, 32'hFFFF_FFFE);
        wr(A_CNT_HI, 32'h5);
        idle(4);
        rd(A_CNT_HI, 32'h5, 10);
        wr(A_CTRL, 32'h1);
        idle(7);
        rd(A_CNT_HI, 32'h6, 10);
        rd(A_CNT_LO, 32'h3, 10);

        idle(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule